// File: doc/BRIEF.md
# Memory Path Test Traffic Generator

This block exercises the user-side command port of an SDRAM controller, so that the whole memory path can be checked without any other logic attached. It first issues writes to every location in a configurable box of addresses. Columns form the innermost loop, rows the middle loop and banks the outer loop. The write data comes from one pseudo-random byte generator per byte lane.

Once every write has been accepted, the block issues reads to the same locations in the same order. It rebuilds the expected data from freshly reseeded generators and compares each returned word lane by lane. The per-lane pass flags and the overall pass flag record any miscompare until reset. A one-cycle completion pulse marks the end of each write/read pass, and the block then starts the next pass from the first address by itself.

Top module: `mtg_top`

## Requirements
- R1: Accepted writes visit addresses in this order: column from its first to its last value (innermost), then row from its first to its last value, then bank from 0 to NUM_BANKS-1. With the defaults this gives 256 writes per pass, where write index i goes to column i%16, row (i/16)%4 and bank i/64.
- R2: No read is issued until all writes of the pass have been accepted. Reads then visit the same addresses in the same order as the writes (`cmd_write` is 1 for writes and 0 for reads).
- R3: `pass_all` is 1 after reset and equals the AND of all bits of `pass_lane`. Once it is 0, it stays 0 until reset.
- R4: `pass_lane[k]` goes to 0 when a valid read word's byte k (bits 8k+7:8k) differs from the expected byte. A miscompare in one lane leaves the other lanes at 1. A lane bit that is 0 stays 0 until reset.
- R5: `done_pulse` is high for exactly one cycle per pass, and only after the read data for the last issued read has been compared. Between acceptance of the last read and the pulse, `cmd_req` is 0.
- R6: Write-data byte k comes from an 8-bit LFSR with seed ((k*29) mod 255)+1, which gives 0x01, 0x1E, 0x3B and 0x58 for lanes 0 to 3. The LFSR step is next = {s[6:0], s[7]^s[5]^s[4]^s[3]}. The seed value is used for the first write and the state steps once per accepted write.
- R7: In the cycle after `done_pulse`, the block requests a write to the first address again, with every lane LFSR back at its seed.
- R8: The command address, write data and `cmd_write` change only after a cycle in which `cmd_req` and `cmd_ready` are both 1. They are held while `cmd_req` is 1 and `cmd_ready` is 0.
- R9: `rd_data` is ignored in any cycle in which `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_req | output | 1 | Command request |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_bank | output | BANK_W | Bank address |
| cmd_row | output | ROW_W | Row address |
| cmd_col | output | COL_W | Column address |
| cmd_wdata | output | DATA_W | Write data |
| cmd_ready | input | 1 | Controller accepts the command this cycle |
| rd_valid | input | 1 | Read data valid strobe |
| rd_data | input | DATA_W | Read data, returned in command order |
| pass_all | output | 1 | Sticky overall pass flag |
| pass_lane | output | DATA_W/8 | Sticky per-byte pass flags |
| done_pulse | output | 1 | One-cycle end-of-pass pulse |

## Verification
The assertions assume that the controller returns read data strictly in command order, at least one cycle after the read was accepted, and never returns more words than were requested. The bench memory model holds each accepted read in a FIFO and releases it after a random delay of one to four cycles. It releases at most one word per cycle, and only for reads already accepted. `cmd_ready` is randomized with a fixed seed and includes a directed stall stretch. `rd_data` carries random garbage whenever `rd_valid` is low. A single directed corruption of lane 2 in the second pass exercises the sticky flags.

// File: rtl/mtg_pkg.sv
package mtg_pkg;

    typedef enum logic [1:0] {
        ST_WRITE = 2'd0,
        ST_READ  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } mtg_state_e;

    // Maximal-length 8-bit sequence, polynomial x^8+x^6+x^5+x^4+1
    function automatic logic [7:0] lfsr_next(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    // Distinct nonzero seed per lane (29 is coprime with 255)
    function automatic logic [7:0] lane_seed(input int lane);
        return 8'(((lane * 29) % 255) + 1);
    endfunction

endpackage

// File: rtl/mtg_addr_seq.sv
module mtg_addr_seq #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 12,
    parameter int ROW_FIRST = 0,
    parameter int ROW_LAST  = 3,
    parameter int COL_W     = 10,
    parameter int COL_FIRST = 0,
    parameter int COL_LAST  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic              last
);
    localparam logic [BANK_W-1:0] BANK_MAX = BANK_W'(NUM_BANKS - 1);
    localparam logic [ROW_W-1:0]  ROW_LO   = ROW_W'(ROW_FIRST);
    localparam logic [ROW_W-1:0]  ROW_HI   = ROW_W'(ROW_LAST);
    localparam logic [COL_W-1:0]  COL_LO   = COL_W'(COL_FIRST);
    localparam logic [COL_W-1:0]  COL_HI   = COL_W'(COL_LAST);

    wire col_wrap  = (col == COL_HI);
    wire row_wrap  = (row == ROW_HI);
    wire bank_wrap = (bank == BANK_MAX);

    assign last = col_wrap && row_wrap && bank_wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= '0;
            row  <= ROW_LO;
            col  <= COL_LO;
        end else if (step) begin
            if (col_wrap) begin
                col <= COL_LO;
                if (row_wrap) begin
                    row  <= ROW_LO;
                    bank <= bank_wrap ? '0 : bank + 1'b1;
                end else begin
                    row <= row + 1'b1;
                end
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    a_r1_col_range: assert property (@(posedge clk) disable iff (rst) col <= COL_HI);
    a_r1_row_range: assert property (@(posedge clk) disable iff (rst) row <= ROW_HI);
    a_r1_bank_range: assert property (@(posedge clk) disable iff (rst) bank <= BANK_MAX);
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(col) && $stable(row) && $stable(bank)));

endmodule

// File: rtl/mtg_lfsr_bank.sv
module mtg_lfsr_bank #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reload,
    input  logic               step,
    output logic [8*LANES-1:0] data
);
    import mtg_pkg::*;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] st;
        always_ff @(posedge clk) begin
            if (rst || reload) st <= lane_seed(g);
            else if (step)     st <= lfsr_next(st);
        end
        assign data[8*g +: 8] = st;

        a_r6_nonzero: assert property (@(posedge clk) disable iff (rst) st != 8'h00);
    end

endmodule

// File: rtl/mtg_checker.sv
module mtg_checker #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid,
    input  logic [8*LANES-1:0] actual,
    input  logic [8*LANES-1:0] expected,
    output logic [LANES-1:0]   pass_q
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        wire miss = valid && (actual[8*g +: 8] != expected[8*g +: 8]);
        always_ff @(posedge clk) begin
            if (rst)       pass_q[g] <= 1'b1;
            else if (miss) pass_q[g] <= 1'b0;
        end

        a_r4_clean_keeps: assert property (@(posedge clk) disable iff (rst)
            (pass_q[g] && !miss) |=> pass_q[g]);
        a_r9_no_valid_no_change: assert property (@(posedge clk) disable iff (rst)
            !valid |=> $stable(pass_q[g]));
    end

    a_r4_never_recovers: assert property (@(posedge clk) disable iff (rst)
        (pass_q & ~$past(pass_q)) == '0);

endmodule

// File: rtl/mtg_top.sv
module mtg_top #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int ROW_FIRST = 0,
    parameter int ROW_LAST  = 3,
    parameter int COL_W     = 10,
    parameter int COL_FIRST = 0,
    parameter int COL_LAST  = 15,
    parameter int DATA_W    = 32,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int LANES    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cmd_req,
    output logic              cmd_write,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_ready,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              pass_all,
    output logic [LANES-1:0]  pass_lane,
    output logic              done_pulse
);
    import mtg_pkg::*;

    localparam int TOTAL = NUM_BANKS * (ROW_LAST - ROW_FIRST + 1) * (COL_LAST - COL_FIRST + 1);
    localparam int OUT_W = $clog2(TOTAL + 1);

    mtg_state_e       state;
    logic [OUT_W-1:0] outstanding;
    logic             addr_last;
    logic [DATA_W-1:0] exp_data;

    wire accept  = cmd_req && cmd_ready;
    wire rd_issue = accept && (state == ST_READ);

    assign cmd_req    = (state == ST_WRITE) || (state == ST_READ);
    assign cmd_write  = (state == ST_WRITE);
    assign done_pulse = (state == ST_DONE);

    mtg_addr_seq #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W),
        .ROW_W(ROW_W), .ROW_FIRST(ROW_FIRST), .ROW_LAST(ROW_LAST),
        .COL_W(COL_W), .COL_FIRST(COL_FIRST), .COL_LAST(COL_LAST)
    ) u_addr (
        .clk(clk), .rst(rst), .step(accept),
        .bank(cmd_bank), .row(cmd_row), .col(cmd_col), .last(addr_last)
    );

    mtg_lfsr_bank #(.LANES(LANES)) u_wr_gen (
        .clk(clk), .rst(rst), .reload(done_pulse),
        .step(accept && cmd_write), .data(cmd_wdata)
    );

    mtg_lfsr_bank #(.LANES(LANES)) u_exp_gen (
        .clk(clk), .rst(rst), .reload(done_pulse),
        .step(rd_valid), .data(exp_data)
    );

    mtg_checker #(.LANES(LANES)) u_chk (
        .clk(clk), .rst(rst), .valid(rd_valid),
        .actual(rd_data), .expected(exp_data), .pass_q(pass_lane)
    );

    assign pass_all = &pass_lane;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= '0;
        end else begin
            case ({rd_issue, rd_valid})
                2'b10:   outstanding <= outstanding + 1'b1;
                2'b01:   outstanding <= outstanding - 1'b1;
                default: outstanding <= outstanding;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_WRITE;
        end else begin
            case (state)
                ST_WRITE: if (accept && addr_last) state <= ST_READ;
                ST_READ:  if (accept && addr_last) state <= ST_DRAIN;
                ST_DRAIN: if (outstanding == '0)   state <= ST_DONE;
                default:  state <= ST_WRITE;
            endcase
        end
    end

    // Assumes ordered return, at least one cycle after the read was accepted
    a_r5_valid_expected: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (outstanding != '0));
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);
    a_r5_all_returned: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> (outstanding == '0));
    a_r2_no_read_in_write: assert property (@(posedge clk) disable iff (rst)
        cmd_write |-> (outstanding == '0));
    a_r7_restart_write: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> (cmd_req && cmd_write));
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !cmd_ready) |=> ($stable(cmd_bank) && $stable(cmd_row) &&
            $stable(cmd_col) && $stable(cmd_wdata) && $stable(cmd_write) && cmd_req));
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        !pass_all |=> !pass_all);

endmodule

// File: tb/tb_mtg_top.sv
module tb_mtg_top;
    localparam int LANES = 4;
    localparam int TOTAL = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_req, cmd_write, cmd_ready, rd_valid, pass_all, done_pulse;
    logic [1:0]  cmd_bank;
    logic [11:0] cmd_row;
    logic [9:0]  cmd_col;
    logic [31:0] cmd_wdata, rd_data;
    logic [3:0]  pass_lane;

    always #2.5 clk = ~clk;

    mtg_top dut (
        .clk(clk), .rst(rst), .cmd_req(cmd_req), .cmd_write(cmd_write),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .pass_all(pass_all), .pass_lane(pass_lane),
        .done_pulse(done_pulse)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] step8(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic [7:0] seed8(input int k);
        return 8'(((k * 29) % 255) + 1);
    endfunction

    function automatic logic [23:0] exp_addr(input int i);
        logic [1:0]  b = 2'(i / 64);
        logic [11:0] r = 12'((i / 16) % 4);
        logic [9:0]  c = 10'(i % 16);
        return {b, r, c};
    endfunction

    logic [7:0]  wl [LANES];
    logic [31:0] mem [int];
    logic [31:0] qd [$];
    int          qdue [$];

    function automatic logic [31:0] wl_word();
        logic [31:0] w;
        for (int k = 0; k < LANES; k++) w[8*k +: 8] = wl[k];
        return w;
    endfunction

    initial begin
        int cyc = 0, sweep = 0, wr_idx = 0, rd_idx = 0, rd_ret = 0, last_due = 0;
        bit prev_stall = 0, prev_done = 0, timeout = 0;
        logic [24:0] prev_cmd;
        logic [31:0] prev_wd;
        logic [23:0] a;

        void'($urandom(32'd4242));
        cmd_ready = 0; rd_valid = 0; rd_data = '0;
        for (int k = 0; k < LANES; k++) wl[k] = seed8(k);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(pass_all == 1'b1, "R3", "reset pass_all", 64'(pass_all), 64'd1);
        chk(pass_lane == 4'hF, "R4", "reset pass_lane", 64'(pass_lane), 64'hF);
        chk(done_pulse == 1'b0, "R5", "reset done", 64'(done_pulse), 64'd0);
        chk(cmd_write && {cmd_bank, cmd_row, cmd_col} == 24'd0, "R1", "reset address",
            64'({cmd_write, cmd_bank, cmd_row, cmd_col}), 64'h1000000);
        chk(cmd_wdata == 32'h583B1E01, "R6", "reset seeds", 64'(cmd_wdata), 64'h583B1E01);
        rst = 0;

        while (sweep < 3 && !timeout) begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                timeout = 1;
                chk(0, "R5", "watchdog expired", 64'(cyc), 64'd0);
            end
            // R8: hold while stalled
            if (prev_stall)
                chk({cmd_write, cmd_bank, cmd_row, cmd_col} == prev_cmd && cmd_wdata == prev_wd,
                    "R8", "command held under stall",
                    64'({cmd_write, cmd_bank, cmd_row, cmd_col}), 64'(prev_cmd));
            cmd_ready = (cyc >= 10 && cyc < 16) ? 1'b0 : ($urandom % 4 != 0);
            // read return path, garbage when not valid (R9)
            if (qd.size() > 0 && qdue[0] <= cyc) begin
                rd_valid = 1;
                rd_data  = qd.pop_front();
                void'(qdue.pop_front());
                if (sweep == 1 && rd_ret == 37) rd_data[23:16] = rd_data[23:16] ^ 8'h10;
                rd_ret++;
            end else begin
                rd_valid = 0;
                rd_data  = $urandom;
            end
            if (done_pulse) begin
                chk(!prev_done, "R5", "pulse width one", 64'(prev_done), 64'd0);
                chk(rd_ret == TOTAL && qd.size() == 0, "R5", "all reads returned before done",
                    64'(rd_ret), 64'(TOTAL));
                if (sweep == 0) begin
                    chk(pass_lane == 4'hF, "R9", "clean pass, garbage ignored", 64'(pass_lane), 64'hF);
                    chk(pass_all == 1'b1, "R3", "pass_all after clean pass", 64'(pass_all), 64'd1);
                end else begin
                    chk(pass_lane == 4'b1011, "R4", "only lane 2 failed (sticky)", 64'(pass_lane), 64'hB);
                    chk(pass_all == 1'b0, "R3", "pass_all low and sticky", 64'(pass_all), 64'd0);
                end
                sweep++;
                wr_idx = 0; rd_idx = 0; rd_ret = 0;
                for (int k = 0; k < LANES; k++) wl[k] = seed8(k);
            end
            if (cmd_req && rd_idx == TOTAL)
                chk(0, "R5", "request after last read", 64'(cmd_req), 64'd0);
            if (cmd_req && cmd_ready && !timeout) begin
                if (cmd_write) begin
                    chk(wr_idx < TOTAL, "R2", "write count", 64'(wr_idx), 64'(TOTAL));
                    a = exp_addr(wr_idx);
                    chk({cmd_bank, cmd_row, cmd_col} == a, "R1", "write address",
                        64'({cmd_bank, cmd_row, cmd_col}), 64'(a));
                    chk(cmd_wdata == wl_word(), "R6", "write data", 64'(cmd_wdata), 64'(wl_word()));
                    if (sweep > 0 && wr_idx == 0)
                        chk({cmd_bank, cmd_row, cmd_col} == 24'd0 && cmd_wdata == 32'h583B1E01,
                            "R7", "restart from first address and seeds",
                            64'({cmd_bank, cmd_row, cmd_col, cmd_wdata}), 64'h583B1E01);
                    mem[int'({cmd_bank, cmd_row, cmd_col})] = cmd_wdata;
                    for (int k = 0; k < LANES; k++) wl[k] = step8(wl[k]);
                    wr_idx++;
                end else begin
                    chk(wr_idx == TOTAL, "R2", "read before write sweep done", 64'(wr_idx), 64'(TOTAL));
                    a = exp_addr(rd_idx);
                    chk({cmd_bank, cmd_row, cmd_col} == a, "R2", "read address",
                        64'({cmd_bank, cmd_row, cmd_col}), 64'(a));
                    qd.push_back(mem[int'({cmd_bank, cmd_row, cmd_col})]);
                    last_due = ((cyc + 1 + int'($urandom % 4)) > last_due + 1) ?
                               (cyc + 1 + int'($urandom % 4)) : last_due + 1;
                    qdue.push_back(last_due);
                    rd_idx++;
                end
            end
            prev_stall = cmd_req && !cmd_ready;
            prev_cmd   = {cmd_write, cmd_bank, cmd_row, cmd_col};
            prev_wd    = cmd_wdata;
            prev_done  = done_pulse;
        end
        chk(sweep == 3, "R7", "three passes completed", 64'(sweep), 64'd3);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule